// File: doc/BRIEF.md
# Command Block Ring Fetch Engine

The engine walks a ring of fixed-size command entries that software keeps in memory. It reaches them through a simple request/acknowledge read-write port. Each entry begins with a 32-bit big-endian handover word. That word holds a 16-bit check field, a byte that hardware writes to report progress, and a byte that software writes to arm an entry. Software can also use that byte to ask for a purge or for an interrupt when the entry finishes. The whole word is read and written as one unit, so software can arm or cancel an entry with a single atomic 32-bit update.

For an armed entry, the engine marks the entry as taken in memory before anything else. It then reads the command word and hands the function unit, command code and options to an execute port. It waits for a done pulse and writes the returned status back into the entry. Last, it marks the entry finished, and it can also raise a one-cycle interrupt. An entry that software has cancelled is marked finished without execution. When the head entry is not armed, the engine waits a programmable number of cycles and then reads the entry again.

Top module: `cbq_fetch_engine`

## Requirements
- R1: While reset is held, mem_req, exe_start and irq are all low.
- R2: The entry at the head is taken only when bit 7 (valid) of its software byte is set and bit 6 (finished) of its hardware byte is clear. An entry that does not meet this is not written and not dispatched, and the head stays on it.
- R3: When the head is not taken, the engine reads its handover word again. If each read is acknowledged in the cycle it is issued, consecutive handover-word reads start poll_gap+2 cycles apart.
- R4: Handover word layout: bits 31:16 hold the check field, bits 15:8 the hardware byte and bits 7:0 the software byte. Before a dispatch, the engine writes the word back with hardware bit 7 (taken) set, the finished bit still clear, and the check field and software byte unchanged.
- R5: The command word is entry word 1. Bits 31:24 drive exe_func, bits 23:16 drive exe_cmd and bits 15:0 drive exe_opts, and exe_start pulses for exactly one cycle per dispatched entry. Entries are dispatched in ring order.
- R6: After exe_done, the engine writes entry word 2 as {16'h0000, exe_status}. It then writes the handover word with hardware byte 8'hC0, keeping the check field and software byte.
- R7: If software bit 5 (interrupt) of a completed, non-purged entry is set, irq pulses for one cycle after the final write. Otherwise irq stays low.
- R8: If software bit 6 (purge) is set when the entry is taken, the handover word is written with hardware byte 8'h40 and the check field and software byte unchanged. Word 2 is not written, nothing is dispatched and no interrupt is raised.
- R9: Entry i lies at word address BASE_ADDR + i*ENTRY_WORDS. After entry DEPTH-1 the head returns to entry 0, and no access falls outside the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_gap | input | PW | Idle cycles between polls of an unarmed head |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| exe_start | output | 1 | One-cycle dispatch pulse |
| exe_func | output | 8 | Function unit selector |
| exe_cmd | output | 8 | Command code |
| exe_opts | output | 16 | Command options |
| exe_done | input | 1 | Execution finished pulse |
| exe_status | input | 16 | Status returned with exe_done |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two kinds of fault show up at the ports.

- **Control faults.** A wrong head index or entry base shows at once: the next memory access falls at the wrong address or outside the ring. An entry can be taken with a bad decision on the valid, finished or purge bits. That shows as an unexpected dispatch on the execute port, or as a wrong hardware byte in memory, within one entry's round trip.
- **Data faults.** A corrupted latched handover word shows in the final write: the check field or software byte comes back changed, and the bench checks every entry for this after each lap. A timer miscount shifts the spacing of idle polls by a cycle or more.

// File: rtl/cbq_pkg.sv
package cbq_pkg;

  // software byte (bits 7:0 of the handover word)
  localparam int SW_VALID_BIT = 7;
  localparam int SW_PURGE_BIT = 6;
  localparam int SW_IRQ_BIT   = 5;

  // hardware byte (bits 15:8 of the handover word)
  localparam logic [7:0] HW_TAKEN_MASK = 8'h80;
  localparam logic [7:0] HW_DONE_MASK  = 8'h40;
  localparam int         HW_DONE_BIT   = 6;

  // word offsets inside one entry
  localparam int WORD_HANDOVER = 0;
  localparam int WORD_COMMAND  = 1;
  localparam int WORD_STATUS   = 2;

  typedef struct packed {
    logic [15:0] chk;
    logic [7:0]  hw;
    logic [7:0]  sw;
  } handover_t;

  typedef struct packed {
    logic [7:0]  func;
    logic [7:0]  cmd;
    logic [15:0] opts;
  } cmd_word_t;

  typedef enum logic [2:0] {
    S_POLL,
    S_RD_HAND,
    S_WR_TAKEN,
    S_RD_CMD,
    S_EXEC,
    S_WAIT,
    S_WR_STAT,
    S_WR_DONE
  } eng_state_e;

endpackage

// File: rtl/cbq_head_ptr.sv
module cbq_head_ptr #(
  parameter int DEPTH       = 8,
  parameter int AW          = 16,
  parameter int ENTRY_WORDS = 4,
  parameter int BASE_ADDR   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [AW-1:0] entry_base
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (advance) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_d;
  end

  assign entry_base = AW'(BASE_ADDR) + AW'(ENTRY_WORDS) * AW'(idx_q);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (idx_q == '0) || (idx_q == $past(idx_q) + 1'b1)); // R9
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST); // R9

endmodule

// File: rtl/cbq_poll_timer.sv
module cbq_poll_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] gap,
  output logic          expired
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load || (cnt_q != '0);
    if (load)               cnt_d = gap;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  AST_POLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/cbq_fetch_engine.sv
module cbq_fetch_engine
  import cbq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int AW          = 16,
  parameter int ENTRY_WORDS = 4,
  parameter int BASE_ADDR   = 16,
  parameter int PW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] poll_gap,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          exe_start,
  output logic [7:0]    exe_func,
  output logic [7:0]    exe_cmd,
  output logic [15:0]   exe_opts,
  input  logic          exe_done,
  input  logic [15:0]   exe_status,
  output logic          irq
);

  // asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  eng_state_e    state_q, state_d;
  handover_t     hand_q, rd_hand;
  cmd_word_t     cmd_q;
  logic [15:0]   stat_q;
  logic          hand_en, cmd_en, stat_en;
  logic          irq_q, irq_d;
  logic          advance, tmr_load, tmr_expired, take, purge_q;
  logic [AW-1:0] entry_base;

  assign rd_hand = handover_t'(mem_rdata);
  assign take    = rd_hand.sw[SW_VALID_BIT] && !rd_hand.hw[HW_DONE_BIT];
  assign purge_q = hand_q.sw[SW_PURGE_BIT];

  cbq_head_ptr #(
    .DEPTH(DEPTH), .AW(AW), .ENTRY_WORDS(ENTRY_WORDS), .BASE_ADDR(BASE_ADDR)
  ) u_ptr (
    .clk(clk), .rst_n(rst_ni), .advance(advance), .entry_base(entry_base)
  );

  cbq_poll_timer #(.PW(PW)) u_tmr (
    .clk(clk), .rst_n(rst_ni), .load(tmr_load), .gap(poll_gap), .expired(tmr_expired)
  );

  always_comb begin
    state_d   = state_q;
    hand_en   = 1'b0;
    cmd_en    = 1'b0;
    stat_en   = 1'b0;
    tmr_load  = 1'b0;
    advance   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = entry_base + AW'(WORD_HANDOVER);
    mem_wdata = '0;
    case (state_q)
      S_POLL: if (tmr_expired) state_d = S_RD_HAND;
      S_RD_HAND: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          hand_en = 1'b1;
          if (!take) begin
            state_d  = S_POLL;
            tmr_load = 1'b1;
          end else if (rd_hand.sw[SW_PURGE_BIT]) begin
            state_d = S_WR_DONE;
          end else begin
            state_d = S_WR_TAKEN;
          end
        end
      end
      S_WR_TAKEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {hand_q.chk, hand_q.hw | HW_TAKEN_MASK, hand_q.sw};
        if (mem_ack) state_d = S_RD_CMD;
      end
      S_RD_CMD: begin
        mem_req  = 1'b1;
        mem_addr = entry_base + AW'(WORD_COMMAND);
        if (mem_ack) begin
          cmd_en  = 1'b1;
          state_d = S_EXEC;
        end
      end
      S_EXEC: state_d = S_WAIT;
      S_WAIT: begin
        if (exe_done) begin
          stat_en = 1'b1;
          state_d = S_WR_STAT;
        end
      end
      S_WR_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = entry_base + AW'(WORD_STATUS);
        mem_wdata = {16'h0000, stat_q};
        if (mem_ack) state_d = S_WR_DONE;
      end
      S_WR_DONE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {hand_q.chk,
                     hand_q.hw | HW_DONE_MASK | (purge_q ? 8'h00 : HW_TAKEN_MASK),
                     hand_q.sw};
        if (mem_ack) begin
          advance = 1'b1;
          state_d = S_RD_HAND;
        end
      end
      default: state_d = S_POLL;
    endcase
  end

  assign irq_d = advance && hand_q.sw[SW_IRQ_BIT] && !purge_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_POLL;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hand_q <= '0;
      cmd_q  <= '0;
      stat_q <= '0;
    end else begin
      if (hand_en) hand_q <= rd_hand;
      if (cmd_en)  cmd_q  <= cmd_word_t'(mem_rdata);
      if (stat_en) stat_q <= exe_status;
    end
  end

  assign exe_start = (state_q == S_EXEC);
  assign exe_func  = cmd_q.func;
  assign exe_cmd   = cmd_q.cmd;
  assign exe_opts  = cmd_q.opts;
  assign irq       = irq_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    exe_start |=> !exe_start); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |=> !irq); // R7
  AST_PURGE_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_ni)
    exe_start |-> !purge_q); // R8
  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_ni)
    exe_start |-> (hand_q.sw[SW_VALID_BIT] && !hand_q.hw[HW_DONE_BIT])); // R2

endmodule

// File: tb/sim_cbq_fetch_engine.sv
module sim_cbq_fetch_engine;
  localparam int DEPTH = 8;
  localparam int EW    = 4;
  localparam int BASE  = 16;
  localparam int AW    = 16;
  localparam int PW    = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] poll_gap;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          exe_start, exe_done, irq;
  logic [7:0]    exe_func, exe_cmd;
  logic [15:0]   exe_opts, exe_status;

  always #5 clk = ~clk;

  cbq_fetch_engine #(.DEPTH(DEPTH), .AW(AW), .ENTRY_WORDS(EW), .BASE_ADDR(BASE), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .poll_gap(poll_gap),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .exe_start(exe_start), .exe_func(exe_func), .exe_cmd(exe_cmd), .exe_opts(exe_opts),
    .exe_done(exe_done), .exe_status(exe_status), .irq(irq)
  );

  int checks = 0, fails = 0, cyc = 0, finished = 0;
  logic [31:0] mem [64];
  int  bad_acc = 0, nwr = 0, wcnt = 0;
  bit  rand_wait = 0;
  int  rd_rises = 0, last_rd_cyc = 0, last_rd_gap = 0;
  bit  req_prev = 0;
  int  irq_n = 0, exp_irq = 0;
  int  disp_n = 0, exp_n = 0;
  logic [7:0]  exp_func [256];
  logic [7:0]  exp_cmd  [256];
  logic [15:0] exp_opts [256];
  int          exp_idx  [256];
  logic [15:0] e_chk [DEPTH];
  logic [7:0]  e_sw  [DEPTH];
  logic [7:0]  e_func [DEPTH];
  logic [7:0]  e_cmd  [DEPTH];
  logic [15:0] e_opts [DEPTH];
  bit          e_purge [DEPTH];
  int  busy = 0, lat = 0;
  logic [15:0] cur_stat;

  function automatic logic [15:0] f_status(logic [7:0] f, logic [7:0] c, logic [15:0] o);
    return o ^ {f, c} ^ 16'h5A5A;
  endfunction

  function automatic int hand_addr(int i);
    return BASE + i * EW;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers at negedges, ack lasts one cycle
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt == 0) begin
        mem_ack <= 1'b1;
        if (mem_addr < AW'(BASE) || mem_addr >= AW'(BASE + DEPTH * EW)) bad_acc++;
        else if (mem_we) begin
          mem[mem_addr[5:0]] = mem_wdata;
          nwr++;
        end else mem_rdata <= mem[mem_addr[5:0]];
        wcnt = rand_wait ? int'($urandom_range(2, 0)) : 0;
      end else wcnt--;
    end
  end

  // read-start monitor and irq counter
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && !req_prev && !mem_we) begin
        last_rd_gap = cyc - last_rd_cyc;
        last_rd_cyc = cyc;
        rd_rises++;
      end
      if (irq) irq_n++;
    end
    req_prev = mem_req;
  end

  // execute model with dispatch checks
  always @(negedge clk) begin
    if (!rst_n) begin
      exe_done <= 1'b0;
      busy = 0;
    end else begin
      exe_done <= 1'b0;
      if (exe_start) begin
        if (disp_n >= exp_n) begin
          chk(0, "R8 unexpected dispatch", {8'h0, exe_func, exe_opts}, 32'h0);
        end else begin
          chk({exe_func, exe_cmd, exe_opts} == {exp_func[disp_n], exp_cmd[disp_n], exp_opts[disp_n]},
              "R5 dispatch fields", {exe_func, exe_cmd, exe_opts},
              {exp_func[disp_n], exp_cmd[disp_n], exp_opts[disp_n]});
          chk(mem[hand_addr(exp_idx[disp_n])][15:8] == 8'h80, "R4 taken before dispatch",
              {24'h0, mem[hand_addr(exp_idx[disp_n])][15:8]}, 32'h80);
        end
        disp_n++;
        cur_stat = f_status(exe_func, exe_cmd, exe_opts);
        lat = int'($urandom_range(3, 0));
        busy = 1;
      end else if (busy == 1) begin
        if (lat == 0) begin
          exe_done   <= 1'b1;
          exe_status <= cur_stat;
          busy = 0;
        end else lat--;
      end
    end
  end

  task automatic arm(input int i, input logic [7:0] hw);
    mem[hand_addr(i)]     = {e_chk[i], hw, e_sw[i]};
    mem[hand_addr(i) + 1] = {e_func[i], e_cmd[i], e_opts[i]};
    mem[hand_addr(i) + 2] = 32'hDEAD_BEEF;
  endtask

  task automatic wait_done(input int i);
    int t = 0;
    while (mem[hand_addr(i)][14] !== 1'b1 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) chk(0, "R2 entry never finished", i, 32'h0);
  endtask

  task automatic run_lap(input int mode);
    int base_disp;
    for (int i = 0; i < DEPTH; i++) begin
      bit pg, iq;
      pg = ($urandom_range(4, 0) == 0);
      iq = $urandom_range(1, 0);
      if (mode == 0) begin
        pg = (i == 2) || (i == 5);
        iq = (i == 5) || (i == 6) || (i == 0);
      end
      e_purge[i] = pg;
      e_chk[i]   = 16'($urandom);
      e_sw[i]    = {1'b1, pg, iq, 5'($urandom)};
      e_func[i]  = 8'($urandom);
      e_cmd[i]   = 8'($urandom);
      e_opts[i]  = 16'($urandom);
      if (!pg) begin
        exp_func[exp_n] = e_func[i];
        exp_cmd[exp_n]  = e_cmd[i];
        exp_opts[exp_n] = e_opts[i];
        exp_idx[exp_n]  = i;
        exp_n++;
        if (iq) exp_irq++;
      end
    end
    base_disp = disp_n;
    for (int i = DEPTH - 1; i >= 0; i--) arm(i, (mode == 1 && i == 1) ? 8'h40 : 8'h00);
    if (mode == 1) begin
      wait_done(0);
      repeat (300) @(negedge clk);
      chk(mem[hand_addr(1)] == {e_chk[1], 8'h40, e_sw[1]}, "R2 finished entry untouched",
          mem[hand_addr(1)], {e_chk[1], 8'h40, e_sw[1]});
      chk(mem[hand_addr(2)][15:8] == 8'h00, "R2 head stays on skipped entry",
          {24'h0, mem[hand_addr(2)][15:8]}, 32'h0);
      chk(disp_n == base_disp + (e_purge[0] ? 0 : 1), "R2 no dispatch of finished entry",
          disp_n, base_disp + (e_purge[0] ? 0 : 1));
      mem[hand_addr(1)] = {e_chk[1], 8'h00, e_sw[1]};
    end
    for (int i = 0; i < DEPTH; i++) wait_done(i);
    repeat (20) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      if (e_purge[i]) begin
        chk(mem[hand_addr(i)] == {e_chk[i], 8'h40, e_sw[i]}, "R8 purged handover",
            mem[hand_addr(i)], {e_chk[i], 8'h40, e_sw[i]});
        chk(mem[hand_addr(i) + 2] == 32'hDEAD_BEEF, "R8 purged status untouched",
            mem[hand_addr(i) + 2], 32'hDEAD_BEEF);
      end else begin
        chk(mem[hand_addr(i)] == {e_chk[i], 8'hC0, e_sw[i]}, "R6 finished handover",
            mem[hand_addr(i)], {e_chk[i], 8'hC0, e_sw[i]});
        chk(mem[hand_addr(i) + 2] == {16'h0, f_status(e_func[i], e_cmd[i], e_opts[i])},
            "R6 status word", mem[hand_addr(i) + 2],
            {16'h0, f_status(e_func[i], e_cmd[i], e_opts[i])});
      end
    end
    chk(disp_n == exp_n, "R5 dispatch count", disp_n, exp_n);
    chk(irq_n == exp_irq, "R7 interrupt count", irq_n, exp_irq);
    chk(bad_acc == 0, "R9 accesses inside ring", bad_acc, 0);
  endtask

  task automatic measure_poll(input int gap);
    int start;
    poll_gap = PW'(gap);
    start = rd_rises;
    while (rd_rises < start + 3) @(negedge clk);
    chk(last_rd_gap == gap + 2, "R3 poll spacing", last_rd_gap, gap + 2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 190000);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rst_n    = 1'b0;
    poll_gap = PW'(5);
    repeat (4) @(negedge clk);
    chk(mem_req == 1'b0, "R1 mem_req in reset", mem_req, 0);
    chk(exe_start == 1'b0, "R1 exe_start in reset", exe_start, 0);
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    measure_poll(5);
    measure_poll(0);
    measure_poll(3);
    chk(nwr == 0, "R2 no write to unarmed head", nwr, 0);
    chk(disp_n == 0, "R2 no dispatch of unarmed head", disp_n, 0);
    poll_gap  = PW'(2);
    rand_wait = 1;
    run_lap(0);
    run_lap(1);
    for (int l = 0; l < 4; l++) run_lap(2);
    finish_run();
  end

endmodule